// File: doc/BRIEF.md
# Update-Bounded Multi-Pivot Longest-Prefix Lookup Engine

This block finds, for a destination address, the longest stored route prefix, using only a short set of bitmaps. The bitmaps exist only at evenly spaced pivot lengths (multiples of `STRIDE` bits, up to `STRIDE*LEVELS`). A prefix whose length falls between two pivots is widened to the next pivot at or above its length. It then occupies a run of `2^(pivot-length)` adjacent bits. Each bitmap is stored as words of `2^STRIDE` bits, so the run of any one prefix lies in a single word. The recommended deployment setting is `STRIDE=6`, `LEVELS=4`, which gives pivots at 6, 12, 18 and 24 with 64-bit words. The defaults are smaller (pivots 4, 8 and 12 with 16-bit words) so that the storage stays small.

A lookup reads one bit from every pivot bank in parallel, which is one read per pivot. One cycle later it reports whether any bank matched, which pivot was the longest match, and the address bits down to that pivot. The address bits serve as the index for a next-hop fetch elsewhere. An update inserts or deletes one prefix with a single masked write to one word of one bank, so it costs exactly one on-chip access. Storage of next hops and prefixes longer than the last pivot are handled outside this block.

Top module: `multi_pivot_lpm`

## Requirements
- R1: After a synchronous active-low reset, every bitmap bit is clear. Every lookup then reports a miss with `res_level`=0 and `res_index`=0.
- R2: `res_vld` is high in exactly the cycle after each cycle with `lk_req` high, and low otherwise.
- R3: An insert of length L with 1 <= L <= STRIDE*LEVELS is stored at pivot index ceil(L/STRIDE)-1. Pivot index k stands for prefix length STRIDE*(k+1), and `res_level` reports k. A lookup of any address whose top L bits equal the prefix then hits at that pivot or at a longer one.
- R4: The widened prefix covers exactly the 2^(P-L) pivot positions that share its top L bits, where P is the target pivot length. An address that differs from the prefix within the top L bits does not hit through it.
- R5: When several pivots match an address, the result reports the longest one.
- R6: On a hit at pivot index k, `res_index` equals the top STRIDE*(k+1) address bits, right-aligned and zero-extended.
- R7: A delete (`upd_del`=1) clears exactly the positions that an insert of the same prefix and length would set. Other bits in that word are left unchanged.
- R8: An update with length 0 or a length greater than STRIDE*LEVELS changes no bitmap bit.
- R9: When a lookup and an update occur in the same cycle, the lookup returns the result from before the update. A lookup in the next cycle sees the update.
- R10: Each update writes at most one word in one pivot bank.
- R11: Prefix bits below the given length, and address bits below the last pivot, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request this cycle |
| lk_addr | input | ADDR_W | Address to look up; the top STRIDE*LEVELS bits are used |
| upd_req | input | 1 | Update request this cycle |
| upd_del | input | 1 | 0 = insert prefix, 1 = delete prefix |
| upd_prefix | input | ADDR_W | Prefix value, left-aligned |
| upd_len | input | LEN_W | Prefix length in bits |
| res_vld | output | 1 | Lookup result valid |
| res_hit | output | 1 | Some pivot matched |
| res_level | output | LVL_W | Index of the longest matching pivot |
| res_index | output | STRIDE*LEVELS | Address bits down to the matched pivot, right-aligned |

## Verification
A wrong mask or word address in a pivot bank stays hidden until a lookup lands on the corrupted position. It then shows up one cycle later as a wrong `res_hit` or `res_level`, or as a stale hit after a delete. For that reason the bench follows every update with lookups both inside and just outside the widened range, and with lookups on other prefixes in the same word. A wrong priority or index shows up immediately on addresses that are covered by two pivots. A wrong read-versus-write order shows up only on a lookup issued in the same cycle as an update to the same word. The bench therefore issues such pairs on purpose, and also mixes a long stream of random updates and lookups against a bit-level model.

// File: rtl/lpm_pkg.sv
// Shared types for the multi-pivot lookup engine.
// Assumes nothing beyond IEEE 1800-2017 packages.
package lpm_pkg;

    typedef enum logic {
        OP_INSERT = 1'b0,
        OP_DELETE = 1'b1
    } upd_op_e;

endpackage

// File: rtl/upd_mask_gen.sv
// Update decoder: turns a prefix and length into one pivot bank, one word
// address and a bit mask covering the widened prefix inside that word.
// Assumes ADDR_W > STRIDE*LEVELS. A length outside 1..STRIDE*LEVELS gives no write.
module upd_mask_gen #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 4,
    parameter int LEVELS = 3,
    parameter int LEN_W  = 6
) (
    input  logic                          upd_req,
    input  logic                          upd_del,
    input  logic [ADDR_W-1:0]             upd_prefix,
    input  logic [LEN_W-1:0]              upd_len,
    output logic [LEVELS-1:0]             we_lvl,
    output lpm_pkg::upd_op_e              op,
    output logic [STRIDE*LEVELS-1:0]      word_addr,
    output logic [(1<<STRIDE)-1:0]        mask
);
    localparam int MAXP = STRIDE * LEVELS;
    localparam int W    = 1 << STRIDE;

    logic [MAXP-1:0]   key;
    logic [STRIDE-1:0] sub;
    logic              len_ok;
    int                lvl_i;
    int                span_i;
    logic              unused_low;

    assign key        = upd_prefix[ADDR_W-1 -: MAXP];
    assign unused_low = ^upd_prefix[ADDR_W-MAXP-1:0];
    assign op         = upd_del ? lpm_pkg::OP_DELETE : lpm_pkg::OP_INSERT;

    // Pick the target pivot, the word in it and the widened bit run.
    always_comb begin
        len_ok = upd_req && (upd_len != '0) && (int'(upd_len) <= MAXP);
        lvl_i  = 0;
        for (int g = 0; g < LEVELS; g++) begin
            if (int'(upd_len) > STRIDE * g && int'(upd_len) <= STRIDE * (g + 1))
                lvl_i = g;
        end
        span_i    = len_ok ? (STRIDE * (lvl_i + 1) - int'(upd_len)) : 0;
        word_addr = MAXP'(key >> (MAXP - STRIDE * lvl_i));
        sub       = STRIDE'(key >> (MAXP - STRIDE * (lvl_i + 1)));
        for (int i = 0; i < W; i++)
            mask[i] = ((i >> span_i) == (int'(sub) >> span_i));
        for (int g = 0; g < LEVELS; g++)
            we_lvl[g] = len_ok && (lvl_i == g);
    end

endmodule

// File: rtl/pivot_bank.sv
// One pivot bitmap: words of 2^STRIDE bits, a masked read-modify-write port
// for updates and a registered single-bit read for lookups. Both happen in
// the same edge; the read sees the word from before the write.
// Level 0 keeps two words so that its address is one bit wide; only word 0 is used.
module pivot_bank #(
    parameter int STRIDE = 4,
    parameter int LEVELS = 3,
    parameter int LEVEL  = 0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [STRIDE*LEVELS-1:0]      lk_key,
    input  logic                          we,
    input  lpm_pkg::upd_op_e              op,
    input  logic [STRIDE*LEVELS-1:0]      upd_word,
    input  logic [(1<<STRIDE)-1:0]        upd_mask,
    output logic                          hit_q
);
    localparam int MAXP  = STRIDE * LEVELS;
    localparam int W     = 1 << STRIDE;
    localparam int AWK   = (LEVEL == 0) ? 1 : STRIDE * LEVEL;
    localparam int DEPTH = 1 << AWK;

    logic [W-1:0]      mem [DEPTH];
    logic [AWK-1:0]    rd_w;
    logic [STRIDE-1:0] rd_b;
    logic [AWK-1:0]    wr_w;

    assign rd_w = AWK'(lk_key >> (MAXP - STRIDE * LEVEL));
    assign rd_b = STRIDE'(lk_key >> (MAXP - STRIDE * (LEVEL + 1)));
    assign wr_w = AWK'(upd_word);

    // Clear on reset; otherwise read one bit and apply the masked update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= mem[rd_w][rd_b];
            if (we) begin
                if (op == lpm_pkg::OP_DELETE) mem[wr_w] <= mem[wr_w] & ~upd_mask;
                else                          mem[wr_w] <= mem[wr_w] | upd_mask;
            end
        end
    end

    // R3: an insert leaves every masked bit set.
    a_r3_insert_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == lpm_pkg::OP_INSERT) |=> ((mem[$past(wr_w)] & $past(upd_mask)) == $past(upd_mask)));

    // R7: a delete leaves every masked bit clear.
    a_r7_delete_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (we && op == lpm_pkg::OP_DELETE) |=> ((mem[$past(wr_w)] & $past(upd_mask)) == '0));

    // R7: bits outside the mask keep their value.
    a_r7_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(wr_w)] & ~$past(upd_mask)) == ($past(mem[wr_w]) & ~$past(upd_mask))));

endmodule

// File: rtl/hit_select.sv
// Priority stage: picks the longest pivot whose bit was set and forms the
// right-aligned next-hop index. Purely combinational on registered inputs.
module hit_select #(
    parameter int STRIDE = 4,
    parameter int LEVELS = 3,
    parameter int LVL_W  = 2
) (
    input  logic [LEVELS-1:0]             hits,
    input  logic [STRIDE*LEVELS-1:0]      key_q,
    output logic                          hit,
    output logic [LVL_W-1:0]              level,
    output logic [STRIDE*LEVELS-1:0]      index
);
    localparam int MAXP = STRIDE * LEVELS;

    int lvl_i;

    // Highest set pivot wins; index is the address cut at that pivot.
    always_comb begin
        hit   = 1'b0;
        lvl_i = 0;
        for (int g = 0; g < LEVELS; g++) begin
            if (hits[g]) begin
                hit   = 1'b1;
                lvl_i = g;
            end
        end
        level = hit ? LVL_W'(lvl_i) : '0;
        index = hit ? MAXP'(key_q >> (MAXP - STRIDE * (lvl_i + 1))) : '0;
    end

endmodule

// File: rtl/multi_pivot_lpm.sv
// Top of the multi-pivot longest-prefix lookup engine. One lookup and one
// update may arrive each cycle; the lookup result follows one cycle later.
// Assumes ADDR_W > STRIDE*LEVELS and LEN_W wide enough for ADDR_W.
module multi_pivot_lpm #(
    parameter int ADDR_W = 32,
    parameter int STRIDE = 4,
    parameter int LEVELS = 3,
    parameter int LEN_W  = $clog2(ADDR_W + 1),
    parameter int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          lk_req,
    input  logic [ADDR_W-1:0]             lk_addr,
    input  logic                          upd_req,
    input  logic                          upd_del,
    input  logic [ADDR_W-1:0]             upd_prefix,
    input  logic [LEN_W-1:0]              upd_len,
    output logic                          res_vld,
    output logic                          res_hit,
    output logic [LVL_W-1:0]              res_level,
    output logic [STRIDE*LEVELS-1:0]      res_index
);
    localparam int MAXP = STRIDE * LEVELS;
    localparam int W    = 1 << STRIDE;

    logic [MAXP-1:0]    lk_key;
    logic [MAXP-1:0]    key_q;
    logic               vld_q;
    logic [LEVELS-1:0]  we_lvl;
    logic [LEVELS-1:0]  hits;
    lpm_pkg::upd_op_e   op;
    logic [MAXP-1:0]    word_addr;
    logic [W-1:0]       mask;
    logic               sel_hit;
    logic [LVL_W-1:0]   sel_level;
    logic [MAXP-1:0]    sel_index;
    logic               unused_addr_low;

    assign lk_key          = lk_addr[ADDR_W-1 -: MAXP];
    assign unused_addr_low = ^lk_addr[ADDR_W-MAXP-1:0];

    upd_mask_gen #(.ADDR_W(ADDR_W), .STRIDE(STRIDE), .LEVELS(LEVELS), .LEN_W(LEN_W)) u_mask (
        .upd_req(upd_req), .upd_del(upd_del), .upd_prefix(upd_prefix), .upd_len(upd_len),
        .we_lvl(we_lvl), .op(op), .word_addr(word_addr), .mask(mask)
    );

    for (genvar g = 0; g < LEVELS; g++) begin : g_bank
        pivot_bank #(.STRIDE(STRIDE), .LEVELS(LEVELS), .LEVEL(g)) u_bank (
            .clk(clk), .rst_n(rst_n), .lk_key(lk_key), .we(we_lvl[g]), .op(op),
            .upd_word(word_addr), .upd_mask(mask), .hit_q(hits[g])
        );
    end

    // Track which cycle carries a lookup result and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            key_q <= '0;
        end else begin
            vld_q <= lk_req;
            if (lk_req) key_q <= lk_key;
        end
    end

    hit_select #(.STRIDE(STRIDE), .LEVELS(LEVELS), .LVL_W(LVL_W)) u_sel (
        .hits(hits), .key_q(key_q), .hit(sel_hit), .level(sel_level), .index(sel_index)
    );

    assign res_vld   = vld_q;
    assign res_hit   = vld_q & sel_hit;
    assign res_level = res_hit ? sel_level : '0;
    assign res_index = res_hit ? sel_index : '0;

    // R2: every request yields a result next cycle.
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> res_vld);

    // R2: no result without a request.
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !res_vld);

    // R10: at most one bank written per update.
    a_r10_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_lvl));

    // R8: out-of-range lengths never reach a bank.
    a_r8_bad_len_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_req && (upd_len == '0 || int'(upd_len) > MAXP)) |-> (we_lvl == '0));

    // R1: a miss carries zero level and index.
    a_r1_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && !res_hit) |-> (res_level == '0 && res_index == '0));

endmodule

// File: tb/test_multi_pivot_lpm.sv
// Scoreboard bench: the driver computes expected results from a bit-level
// model and queues them; the monitor pops and compares each result.
module test_multi_pivot_lpm;
    localparam int CLK_PERIOD = 10;
    localparam int S    = 4;
    localparam int LV   = 3;
    localparam int MAXP = S * LV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        upd_req = 1'b0;
    logic        upd_del = 1'b0;
    logic [31:0] upd_prefix = '0;
    logic [5:0]  upd_len = '0;
    logic        res_vld;
    logic        res_hit;
    logic [1:0]  res_level;
    logic [11:0] res_index;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit    hit;
        int    lvl;
        int    idx;
        string tag;
    } exp_t;
    exp_t q[$];

    bit rb [LV][1 << MAXP];

    always #(CLK_PERIOD / 2) clk = ~clk;

    multi_pivot_lpm i_multi_pivot_lpm (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
        .upd_req(upd_req), .upd_del(upd_del), .upd_prefix(upd_prefix), .upd_len(upd_len),
        .res_vld(res_vld), .res_hit(res_hit), .res_level(res_level), .res_index(res_index)
    );

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic void model_update(input logic [11:0] pkey, input int len, input bit del);
        int g, p, start;
        if (len < 1 || len > MAXP) return;
        g = (len - 1) / S;
        p = S * (g + 1);
        start = (int'(pkey) >> (MAXP - len)) << (p - len);
        for (int i = 0; i < (1 << (p - len)); i++) rb[g][start + i] = !del;
    endfunction

    function automatic exp_t model_lookup(input logic [11:0] akey, input string tag);
        exp_t e;
        e.hit = 1'b0; e.lvl = 0; e.idx = 0; e.tag = tag;
        for (int g = 0; g < LV; g++) begin
            int idx;
            idx = int'(akey) >> (MAXP - S * (g + 1));
            if (rb[g][idx]) begin e.hit = 1'b1; e.lvl = g; e.idx = idx; end
        end
        return e;
    endfunction

    // One cycle of stimulus: optional lookup and optional update.
    task automatic op(input bit lk, input logic [11:0] akey, input bit up, input bit del,
                      input logic [11:0] pkey, input int len, input string tag);
        @(negedge clk);
        if (lk) q.push_back(model_lookup(akey, tag));
        if (up) model_update(pkey, len, del);
        lk_req     = lk;
        lk_addr    = {akey, 20'hA5C3E};
        upd_req    = up;
        upd_del    = del;
        upd_prefix = {pkey, 20'hFFFFF};
        upd_len    = 6'(len);
    endtask

    task automatic look(input logic [11:0] akey, input string tag);
        op(1'b1, akey, 1'b0, 1'b0, 12'h0, 0, tag);
    endtask

    task automatic upd(input logic [11:0] pkey, input int len, input bit del);
        op(1'b0, 12'h0, 1'b1, del, pkey, len, "upd");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lk_req = 1'b0; upd_req = 1'b0;
        end
    endtask

    // Monitor: compare each produced result with the queue head.
    always @(negedge clk) begin
        if (rst_n && res_vld === 1'b1) begin
            if (q.size() == 0) begin
                check(1'b0, "R2", "unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(res_hit === e.hit, e.tag, "hit", int'(res_hit), int'(e.hit));
                check(res_level === 2'(e.lvl), e.tag, "level", int'(res_level), e.lvl);
                check(res_index === 12'(e.idx), e.tag, "index", int'(res_index), e.idx);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(res_vld === 1'b0, "R1", "res_vld after reset", int'(res_vld), 0);

        // R1: empty tables miss everywhere.
        look(12'h000, "R1"); look(12'hA55, "R1"); look(12'hFFF, "R1");

        // R3/R6: short prefix pushed to the first pivot.
        upd(12'hA00, 4, 1'b0);
        look(12'hA55, "R3"); look(12'hAF0, "R6");

        // R4: length 6 widens to 4 positions B4..B7 at pivot 8.
        upd(12'hB40, 6, 1'b0);
        look(12'hB45, "R4"); look(12'hB7F, "R4"); look(12'hB83, "R4"); look(12'hB3F, "R4");

        // R5: longer pivot wins where it overlaps.
        upd(12'hB46, 11, 1'b0);
        look(12'hB47, "R5"); look(12'hB46, "R5"); look(12'hB45, "R5"); look(12'hB48, "R5");

        // R11: junk below the length is ignored.
        upd(12'h3FF, 6, 1'b0);
        look(12'h3C0, "R11"); look(12'h3FF, "R11"); look(12'h400, "R11");

        // R8: length 0 and 13 change nothing.
        upd(12'hFFF, 0, 1'b0);
        upd(12'hE00, 13, 1'b0);
        look(12'hFFF, "R8"); look(12'hE00, "R8"); look(12'h000, "R8");

        // R7: delete clears only its run; a neighbour in the same word stays.
        upd(12'hB00, 8, 1'b0);
        upd(12'hB40, 6, 1'b1);
        look(12'hB05, "R7"); look(12'hB45, "R7"); look(12'hB47, "R7"); look(12'hB6A, "R7");

        // R9: same-cycle lookup sees the old word, next cycle the new one.
        op(1'b1, 12'h123, 1'b1, 1'b0, 12'h123, 12, "R9");
        look(12'h123, "R9");
        op(1'b1, 12'h123, 1'b1, 1'b1, 12'h123, 12, "R9");
        look(12'h123, "R9");

        // R10: random mix of updates and lookups against the model.
        for (int i = 0; i < 600; i++) begin
            bit lk, up, del;
            lk  = ($urandom_range(0, 3) != 0);
            up  = ($urandom_range(0, 2) == 0);
            del = ($urandom_range(0, 3) == 0);
            op(lk, 12'($urandom), up, del, 12'($urandom), $urandom_range(0, 13), "R10");
        end
        idle(4);
        check(q.size() == 0, "R2", "pending results", q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule